// File: doc/BRIEF.md
# Read-After-Write Stall Unit

This block sits in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no forwarding network. It holds the architectural register file and decides, in the same cycle, whether the instruction in decode may read its operands. Results reach the register file only in writeback. A decode-stage source that names the destination of a live producer in execute or in memory would read a stale value, so the unit raises a stall. The stall freezes the program counter and the fetch/decode register, and a bubble goes into execute. The condition is evaluated again every cycle, so the stall lasts until the producer has moved far enough ahead.

A producer in writeback never causes a stall. The register file behaves as if it wrote in the first half of the cycle and read in the second: a read of the register being written returns the incoming writeback data. Any later read returns the stored value. Memory operands are kept in program order elsewhere in the pipeline, so only register numbers are compared here.

Top module: `raw_stall_unit`

## Requirements
- R1: When a used, nonzero decode source equals `ex_rd` while `ex_we` is high, `stall` is high in that cycle.
- R2: When a used, nonzero decode source equals `mem_rd` while `mem_we` is high, `stall` is high in that cycle.
- R3: A match against the writeback destination never stalls. A read whose address equals `wb_rd`, with `wb_we` high and the address nonzero, returns `wb_data` in that same cycle.
- R4: A producer in execute or memory whose write-enable is low causes no stall, whatever its register number. When no used source matches a live producer, `stall` is low.
- R5: Register 0 always reads as zero, never causes a stall, and a writeback to it is discarded.
- R6: The two source fields are checked independently. A source whose use flag is low causes no stall.
- R7: `bubble_ex` is high in exactly the cycles in which `stall` is high.
- R8: While `rst` is high, `stall` and `bubble_ex` are low, and a writeback is not stored.
- R9: A value written back at a clock edge is returned by a read of that register in any later cycle.
- R10: A read whose address differs from the active writeback destination returns the stored value, not `wb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_rs1 | input | AW | First source register number of the decoding instruction |
| dec_rs2 | input | AW | Second source register number of the decoding instruction |
| dec_use1 | input | 1 | The decoding instruction reads its first source |
| dec_use2 | input | 1 | The decoding instruction reads its second source |
| ex_rd | input | AW | Destination register number of the instruction in execute |
| ex_we | input | 1 | Register write-enable of the instruction in execute |
| mem_rd | input | AW | Destination register number of the instruction in memory |
| mem_we | input | 1 | Register write-enable of the instruction in memory |
| wb_rd | input | AW | Destination register number of the instruction in writeback |
| wb_we | input | 1 | Register write-enable of the instruction in writeback |
| wb_data | input | XLEN | Result written back |
| stall | output | 1 | Hold the program counter and the fetch/decode register |
| bubble_ex | output | 1 | Load a bubble into execute |
| opnd1 | output | XLEN | Value of the first source register |
| opnd2 | output | XLEN | Value of the second source register |

## Verification
The bench uses eight registers. For each source in turn, it sweeps every combination of source number, execute destination, memory destination, both producer write-enables and the use flag. Each combination is predicted arithmetically. This tells a distance-one hit apart from a distance-two hit, and a dead producer or a register 0 match apart from a real dependence. It also shows that one source field cannot trip the stall for the other. Separate sequences write each register through the writeback port while decode reads it in the same cycle and in the next cycle, with the other source pointing elsewhere. These separate the same-cycle bypass from the stored value, and the stored value from a write to register 0 or a write made during reset.

// File: rtl/raw_pkg.sv
package raw_pkg;
  // number of decode source fields compared
  localparam int unsigned NUM_SRC  = 2;
  // stages whose producers can still block decode (execute, memory)
  localparam int unsigned NUM_PROD = 2;
  localparam int unsigned PROD_EX  = 0;
  localparam int unsigned PROD_MEM = 1;
endpackage

// File: rtl/rsu_regfile.sv
module rsu_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  parameter int unsigned NRD  = 2,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0] rdata
);
  logic [XLEN-1:0] store [NREG];
  logic            wr_live;

  assign wr_live = we && !rst && (waddr != '0);

  // no reset on the array so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_live) store[waddr] <= wdata;
  end

  // write-first read: same-cycle write is visible to decode
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0)
        rdata[p] = '0;
      else if (wr_live && (raddr[p] == waddr))
        rdata[p] = wdata;
      else
        rdata[p] = store[raddr[p]];
    end
  end
endmodule

// File: rtl/rsu_src_check.sv
module rsu_src_check #(
  parameter int unsigned AW    = 5,
  parameter int unsigned NPROD = 2
) (
  input  logic                   src_used,
  input  logic [AW-1:0]          src,
  input  logic [NPROD-1:0]       prod_we,
  input  logic [NPROD-1:0][AW-1:0] prod_rd,
  output logic                   hit
);
  logic [NPROD-1:0] match;

  for (genvar k = 0; k < NPROD; k++) begin : g_prod
    assign match[k] = prod_we[k] && (prod_rd[k] == src);
  end

  assign hit = src_used && (src != '0) && (|match);
endmodule

// File: rtl/raw_stall_unit.sv
module raw_stall_unit #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   dec_rs1,
  input  logic [AW-1:0]   dec_rs2,
  input  logic            dec_use1,
  input  logic            dec_use2,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_we,
  input  logic [AW-1:0]   mem_rd,
  input  logic            mem_we,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_we,
  input  logic [XLEN-1:0] wb_data,
  output logic            stall,
  output logic            bubble_ex,
  output logic [XLEN-1:0] opnd1,
  output logic [XLEN-1:0] opnd2
);
  import raw_pkg::*;

  logic [NUM_SRC-1:0][AW-1:0]    src_num;
  logic [NUM_SRC-1:0]            src_use;
  logic [NUM_SRC-1:0]            src_hit;
  logic [NUM_SRC-1:0][XLEN-1:0]  src_val;
  logic [NUM_PROD-1:0]           p_we;
  logic [NUM_PROD-1:0][AW-1:0]   p_rd;
  logic                          hazard;

  assign src_num[0] = dec_rs1;
  assign src_num[1] = dec_rs2;
  assign src_use[0] = dec_use1;
  assign src_use[1] = dec_use2;

  assign p_we[PROD_EX]  = ex_we;
  assign p_rd[PROD_EX]  = ex_rd;
  assign p_we[PROD_MEM] = mem_we;
  assign p_rd[PROD_MEM] = mem_rd;

  rsu_regfile #(
    .XLEN (XLEN),
    .NREG (NREG),
    .NRD  (NUM_SRC)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_we),
    .waddr (wb_rd),
    .wdata (wb_data),
    .raddr (src_num),
    .rdata (src_val)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    rsu_src_check #(
      .AW    (AW),
      .NPROD (NUM_PROD)
    ) u_chk (
      .src_used (src_use[s]),
      .src      (src_num[s]),
      .prod_we  (p_we),
      .prod_rd  (p_rd),
      .hit      (src_hit[s])
    );
  end

  assign hazard    = !rst && (|src_hit);
  assign stall     = hazard;
  assign bubble_ex = hazard;
  assign opnd1     = src_val[0];
  assign opnd2     = src_val[1];
endmodule

// File: rtl/rsu_checker.sv
module rsu_checker #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NREG = 32,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   dec_rs1,
  input logic [AW-1:0]   dec_rs2,
  input logic            dec_use1,
  input logic            dec_use2,
  input logic [AW-1:0]   ex_rd,
  input logic            ex_we,
  input logic [AW-1:0]   mem_rd,
  input logic            mem_we,
  input logic [AW-1:0]   wb_rd,
  input logic            wb_we,
  input logic [XLEN-1:0] wb_data,
  input logic            stall,
  input logic            bubble_ex,
  input logic [XLEN-1:0] opnd1,
  input logic [XLEN-1:0] opnd2
);
  logic a_live, b_live;
  assign a_live = dec_use1 && (dec_rs1 != '0);
  assign b_live = dec_use2 && (dec_rs2 != '0);

  p_ex_stall_r1: assert property (@(posedge clk) disable iff (rst)
    ((a_live && ex_we && ex_rd == dec_rs1) || (b_live && ex_we && ex_rd == dec_rs2)) |-> stall);

  p_mem_stall_r2: assert property (@(posedge clk) disable iff (rst)
    ((a_live && mem_we && mem_rd == dec_rs1) || (b_live && mem_we && mem_rd == dec_rs2)) |-> stall);

  p_wb_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (wb_we && wb_rd == dec_rs1 && dec_rs1 != '0) |-> (opnd1 == wb_data));

  p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !((a_live && ((ex_we && ex_rd == dec_rs1) || (mem_we && mem_rd == dec_rs1))) ||
      (b_live && ((ex_we && ex_rd == dec_rs2) || (mem_we && mem_rd == dec_rs2)))) |-> !stall);

  p_zero_reg_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_rs1 == '0) |-> (opnd1 == '0));

  p_bubble_r7: assert property (@(posedge clk) disable iff (rst)
    bubble_ex == stall);

  p_reset_r8: assert property (@(posedge clk)
    rst |-> (!stall && !bubble_ex));
endmodule

bind raw_stall_unit rsu_checker #(.XLEN(XLEN), .NREG(NREG)) i_chk (
  .clk(clk), .rst(rst), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
  .dec_use1(dec_use1), .dec_use2(dec_use2), .ex_rd(ex_rd), .ex_we(ex_we),
  .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
  .wb_data(wb_data), .stall(stall), .bubble_ex(bubble_ex),
  .opnd1(opnd1), .opnd2(opnd2)
);

// File: tb/test_raw_stall_unit.sv
module test_raw_stall_unit;
  localparam int unsigned XLEN = 8;
  localparam int unsigned NREG = 8;
  localparam int unsigned AW   = $clog2(NREG);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   dec_rs1 = '0, dec_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic            dec_use1 = 1'b0, dec_use2 = 1'b0, ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
  logic [XLEN-1:0] wb_data = '0;
  logic            stall, bubble_ex;
  logic [XLEN-1:0] opnd1, opnd2;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [XLEN-1:0] model [NREG];

  always #10 clk = ~clk;  // 50 MHz

  raw_stall_unit #(.XLEN(XLEN), .NREG(NREG)) i_raw_stall_unit (
    .clk(clk), .rst(rst), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
    .dec_use1(dec_use1), .dec_use2(dec_use2), .ex_rd(ex_rd), .ex_we(ex_we),
    .mem_rd(mem_rd), .mem_we(mem_we), .wb_rd(wb_rd), .wb_we(wb_we),
    .wb_data(wb_data), .stall(stall), .bubble_ex(bubble_ex),
    .opnd1(opnd1), .opnd2(opnd2)
  );

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [XLEN-1:0] seed_val(input int i);
    return XLEN'((i * 37 + 5) % 256);
  endfunction

  // write a register through the writeback port (committed at next posedge)
  task automatic wb_write(input int r, input logic [XLEN-1:0] v);
    @(negedge clk);
    wb_we = 1'b1; wb_rd = AW'(r); wb_data = v;
    @(posedge clk);
    if (!rst && r != 0) model[r] = v;
    @(negedge clk);
    wb_we = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = '0;
    // R8: hazard presented during reset gives no stall
    @(negedge clk);
    dec_use1 = 1'b1; dec_rs1 = 3'd2; ex_we = 1'b1; ex_rd = 3'd2;
    #5;
    check("R8 stall in reset", XLEN'(stall), 0);
    check("R8 bubble in reset", XLEN'(bubble_ex), 0);
    ex_we = 1'b0; dec_use1 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    for (int i = 1; i < NREG; i++) wb_write(i, seed_val(i));

    // R5: write to register 0 discarded
    wb_write(0, 8'hFF);
    @(negedge clk); dec_rs1 = '0; dec_use1 = 1'b1; #5;
    check("R5 reg0 reads zero", opnd1, '0);

    // R8: write during reset not stored
    @(negedge clk); rst = 1'b1;
    wb_write(3, 8'hAA);
    @(negedge clk); rst = 1'b0; dec_rs1 = 3'd3; #5;
    check("R8 write in reset dropped", opnd1, model[3]);

    // R3 / R9 / R10: same-cycle bypass, then stored value
    for (int r = 1; r < NREG; r++) begin
      logic [XLEN-1:0] v;
      int o;
      v = XLEN'(r * 19 + 100);
      o = (r % (NREG - 1)) + 1;
      @(negedge clk);
      ex_we = 1'b0; mem_we = 1'b0;
      dec_use1 = 1'b1; dec_use2 = 1'b1;
      dec_rs1 = AW'(r); dec_rs2 = AW'(o);
      wb_we = 1'b1; wb_rd = AW'(r); wb_data = v;
      #5;
      check("R3 bypass value", opnd1, v);
      check("R3 no stall on wb match", XLEN'(stall), 0);
      check("R10 other port stored value", opnd2, model[o]);
      @(posedge clk); model[r] = v;
      @(negedge clk); wb_we = 1'b0; #5;
      check("R9 stored after write", opnd1, v);
    end

    // R1 R2 R4 R5 R6 R7: exhaustive sweep, one source active at a time
    for (int side = 0; side < 2; side++)
      for (int s = 0; s < NREG; s++)
        for (int e = 0; e < NREG; e++)
          for (int m = 0; m < NREG; m++)
            for (int w = 0; w < 8; w++) begin
              logic ew, mw, u, exp_st;
              ew = w[0]; mw = w[1]; u = w[2];
              @(negedge clk);
              ex_rd = AW'(e); ex_we = ew; mem_rd = AW'(m); mem_we = mw;
              if (side == 0) begin
                dec_rs1 = AW'(s); dec_use1 = u; dec_rs2 = AW'(e); dec_use2 = 1'b0;
              end else begin
                dec_rs2 = AW'(s); dec_use2 = u; dec_rs1 = AW'(m); dec_use1 = 1'b0;
              end
              exp_st = u && (s != 0) && ((ew && e == s) || (mw && m == s));
              #5;
              check("R1 R2 R4 R5 R6 stall", XLEN'(stall), XLEN'(exp_st));
              check("R7 bubble", XLEN'(bubble_ex), XLEN'(exp_st));
              if (side == 0) check("R10 operand", opnd1, model[s]);
              else           check("R10 operand", opnd2, model[s]);
            end

    // R6: both sources used, only second matches memory producer
    @(negedge clk);
    dec_use1 = 1'b1; dec_rs1 = 3'd1; dec_use2 = 1'b1; dec_rs2 = 3'd6;
    ex_we = 1'b1; ex_rd = 3'd4; mem_we = 1'b1; mem_rd = 3'd6;
    #5;
    check("R6 second source alone stalls", XLEN'(stall), 1);
    finish_run();
  end
endmodule